// File: doc/BRIEF.md
# Peripheral DMA Control Registers

This block is the software-facing control plane of a DMA engine that copies data between a cartridge-style peripheral bus and main memory. A CPU writes word-addressed registers. The register index is the byte offset shifted right by two. Writing either of the two length registers launches a transfer in the direction that register stands for. The block does not move any data. It models the time a transfer takes with a cycle countdown, keeps a small status word with busy and interrupt-pending flags, and drives an interrupt request line.

A transfer length is written as the byte count minus one. Only the low `LEN_W` bits of the length register count. The countdown is loaded with half the byte count (rounded down) plus a fixed overhead of `EXTRA_CYCLES`. If the memory-address register holds all ones when a length is written, nothing starts, and the block goes straight into the interrupt state. Writes to the status register are commands and are not stored as data.

Top module: `pdma_ctrl`

## Requirements
- R1: Register index is `wr_addr >> 2` (the low two address bits are ignored). Index 0 is the memory address, 1 the device address, 2 the device-to-memory length, 3 the memory-to-device length, 4 the status word, and 5 up to `NUM_REGS-1` are general registers. Writes to an index at or above `NUM_REGS` change nothing, and reads there return zero.
- R2: A write to any index other than status stores `(old & ~M) | wr_data`, where M has bits 8i+7..8i set when `wr_lanes[i]` is 1. The stored value reads back on `rd_data`, which is combinational in `rd_addr`.
- R3: The status word reads back with bit 0 = busy and bit 3 = interrupt pending, and all other bits zero. Data written to status is never stored.
- R4: A status write with bit 0 set clears busy and pending and stops the countdown, so no completion follows. A status write with bit 1 set clears `irq` and pending from the next cycle.
- R5: A length write while the memory address is not all ones sets busy and pending on the next cycle. It also sets `xfer_bytes` to the low `LEN_W` bits of the merged length plus one, and sets `xfer_to_dev` to 1 for index 3 and to 0 for index 2.
- R6: A length write while the memory address is all ones starts nothing. Busy reads 0, pending reads 1, `irq` is 1 on the next cycle, and `xfer_bytes` and `xfer_to_dev` keep their values.
- R7: After a start, busy stays set for exactly `xfer_bytes/2 + EXTRA_CYCLES` cycles, with the division rounded down.
- R8: When the countdown ends, busy clears and `irq` rises in the same cycle. `irq` then stays high until a status clear command.
- R9: Synchronous active-high reset clears every register, the status word, the countdown, `irq`, `xfer_to_dev` and `xfer_bytes`.
- R10: A length write during a transfer restarts the countdown with the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| wr_lanes | input | 4 | Byte lanes cleared before the OR |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Interrupt request |
| xfer_to_dev | output | 1 | Direction of the latest started transfer (1 = memory to device) |
| xfer_bytes | output | LEN_W+1 | Byte count of the latest started transfer |

## Verification
The bench builds the block with `NUM_REGS=6`, `LEN_W=8` and `EXTRA_CYCLES=3`. A six-entry map in an eight-slot address space makes indices 6 and 7 unmapped, so the zero readback for unmapped indices gets exercised. An 8-bit length field shows that higher length bits are dropped. The short overhead keeps each transfer to a few dozen cycles, so full countdowns, restarts in flight and cancel-before-completion all fit in one short run. On every clock, the bench compares a behavioural model against one scanned register, `irq` and the transfer outputs.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int REG_W  = 32;
    localparam int LANE_N = REG_W / 8;

    // Fixed register indices; decode depends on them.
    localparam int IDX_MEM_ADDR   = 0;
    localparam int IDX_DEV_ADDR   = 1;
    localparam int IDX_LEN_TO_MEM = 2;
    localparam int IDX_LEN_TO_DEV = 3;
    localparam int IDX_STATUS     = 4;

    // Status word bit positions.
    localparam int ST_BUSY = 0;
    localparam int ST_PEND = 3;

    // Status command bits.
    localparam int CMD_CLR_ALL = 0;
    localparam int CMD_CLR_IRQ = 1;

    typedef enum logic [1:0] {
        LAUNCH_NONE  = 2'd0,
        LAUNCH_GO    = 2'd1,
        LAUNCH_FAULT = 2'd2
    } launch_e;

    typedef struct packed {
        logic irq;
        logic pend;
        logic busy;
        logic to_dev;
    } ctl_state_t;

    function automatic logic [REG_W-1:0] lane_bits(input logic [LANE_N-1:0] lanes);
        logic [REG_W-1:0] m;
        for (int i = 0; i < LANE_N; i++) m[8*i +: 8] = {8{lanes[i]}};
        return m;
    endfunction

    function automatic logic [REG_W-1:0] merge_word(input logic [REG_W-1:0] old_v,
                                                    input logic [REG_W-1:0] new_v,
                                                    input logic [LANE_N-1:0] lanes);
        return (old_v & ~lane_bits(lanes)) | new_v;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input ctl_state_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[ST_BUSY] = s.busy;
        w[ST_PEND] = s.pend;
        return w;
    endfunction

endpackage

// File: rtl/pdma_regfile.sv
module pdma_regfile
    import pdma_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic [REG_W-1:0]               wdata,
    input  logic [LANE_N-1:0]              wlanes,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            if (g == IDX_STATUS) begin : g_hole
                assign regs_q[g] = '0;
            end else begin : g_store
                always_ff @(posedge clk) begin
                    if (rst)
                        regs_q[g] <= '0;
                    else if (we && widx == IDX_W'(g))
                        regs_q[g] <= merge_word(regs_q[g], wdata, wlanes);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pdma_countdown.sv
module pdma_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    output logic             done
);

    logic [CNT_W-1:0] count_q;

    assign done = en && (count_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (clear)
            count_q <= '0;
        else if (en && count_q != '0)
            count_q <= count_q - CNT_W'(1);
    end

    // R7: one step per enabled cycle
    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        (en && count_q != '0 && !load && !clear) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // R4: a clear empties the counter
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clear && !load) |=> (count_q == '0));

endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
    import pdma_pkg::*;
#(
    parameter int NUM_REGS     = 8,
    parameter int LEN_W        = 24,
    parameter int EXTRA_CYCLES = 100,
    localparam int ADDR_W      = $clog2(NUM_REGS) + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [LANE_N-1:0]   wr_lanes,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    output logic                irq,
    output logic                xfer_to_dev,
    output logic [LEN_W:0]      xfer_bytes
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int CNT_W = LEN_W + $clog2(EXTRA_CYCLES + 1) + 1;
    localparam logic [IDX_W:0]   LIMIT   = (IDX_W + 1)'(NUM_REGS);
    localparam logic [IDX_W-1:0] I_STAT  = IDX_W'(IDX_STATUS);
    localparam logic [IDX_W-1:0] I_TOMEM = IDX_W'(IDX_LEN_TO_MEM);
    localparam logic [IDX_W-1:0] I_TODEV = IDX_W'(IDX_LEN_TO_DEV);

    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_ok, rd_ok, hit_status, hit_len;
    logic [LEN_W-1:0] len_low;
    logic [LEN_W:0]   bytes_next;
    logic [CNT_W-1:0] cnt_load;
    launch_e          launch;
    ctl_state_t       st_q;
    logic             tmr_done, tmr_clear;

    assign wr_idx     = wr_addr[ADDR_W-1:2];
    assign rd_idx     = rd_addr[ADDR_W-1:2];
    assign wr_ok      = wr_en && ({1'b0, wr_idx} < LIMIT);
    assign rd_ok      = {1'b0, rd_idx} < LIMIT;
    assign hit_status = wr_ok && (wr_idx == I_STAT);
    assign hit_len    = wr_ok && (wr_idx == I_TOMEM || wr_idx == I_TODEV);

    pdma_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_ok && !hit_status),
        .widx   (wr_idx),
        .wdata  (wr_data),
        .wlanes (wr_lanes),
        .regs_q (regs_q)
    );

    // Launch decision uses the length value as it will be stored.
    assign len_low    = LEN_W'(merge_word(regs_q[wr_idx], wr_data, wr_lanes));
    assign bytes_next = {1'b0, len_low} + (LEN_W + 1)'(1);
    assign cnt_load   = CNT_W'(bytes_next >> 1) + CNT_W'(EXTRA_CYCLES);

    always_comb begin
        launch = LAUNCH_NONE;
        if (hit_len)
            launch = (regs_q[IDX_MEM_ADDR] == '1) ? LAUNCH_FAULT : LAUNCH_GO;
    end

    assign tmr_clear = (hit_status && wr_data[CMD_CLR_ALL]) || (launch == LAUNCH_FAULT);

    pdma_countdown #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (st_q.busy),
        .load     (launch == LAUNCH_GO),
        .load_val (cnt_load),
        .clear    (tmr_clear),
        .done     (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            xfer_bytes <= '0;
        end else begin
            if (tmr_done) begin
                st_q.busy <= 1'b0;
                st_q.irq  <= 1'b1;
            end
            if (hit_status) begin
                if (wr_data[CMD_CLR_ALL]) begin
                    st_q.busy <= 1'b0;
                    st_q.pend <= 1'b0;
                end
                if (wr_data[CMD_CLR_IRQ]) begin
                    st_q.irq  <= 1'b0;
                    st_q.pend <= 1'b0;
                end
            end
            unique case (launch)
                LAUNCH_GO: begin
                    st_q.busy   <= 1'b1;
                    st_q.pend   <= 1'b1;
                    st_q.to_dev <= (wr_idx == I_TODEV);
                    xfer_bytes  <= bytes_next;
                end
                LAUNCH_FAULT: begin
                    st_q.busy <= 1'b0;
                    st_q.pend <= 1'b1;
                    st_q.irq  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign irq         = st_q.irq;
    assign xfer_to_dev = st_q.to_dev;

    always_comb begin
        rd_data = '0;
        if (rd_ok)
            rd_data = (rd_idx == I_STAT) ? status_word(st_q) : regs_q[rd_idx];
    end

    a_r5_start_busy: assert property (@(posedge clk) disable iff (rst)
        (launch == LAUNCH_GO) |=> (st_q.busy && st_q.pend));

    a_r6_fault_irq: assert property (@(posedge clk) disable iff (rst)
        (launch == LAUNCH_FAULT) |=> (irq && !st_q.busy && $stable(xfer_bytes)));

    a_r8_done_irq: assert property (@(posedge clk) disable iff (rst)
        (tmr_done && !hit_status && !hit_len) |=> (irq && !st_q.busy));

    a_r4_irq_cleared: assert property (@(posedge clk) disable iff (rst)
        (hit_status && wr_data[CMD_CLR_IRQ]) |=> !irq);

    a_r4_all_cleared: assert property (@(posedge clk) disable iff (rst)
        (hit_status && wr_data[CMD_CLR_ALL]) |=> (!st_q.busy && !st_q.pend));

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !hit_status) |=> irq);

endmodule

// File: tb/pdma_ctrl_test.sv
module pdma_ctrl_test;

    localparam int NR     = 6;
    localparam int LW     = 8;
    localparam int EXTRA  = 3;
    localparam int AW     = $clog2(NR) + 2;
    localparam int SLOTS  = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    wr_lanes = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          irq;
    logic          xfer_to_dev;
    logic [LW:0]   xfer_bytes;

    int checks = 0;
    int errors = 0;
    bit live   = 1'b0;

    pdma_ctrl #(.NUM_REGS(NR), .LEN_W(LW), .EXTRA_CYCLES(EXTRA)) uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_lanes (wr_lanes), .rd_addr (rd_addr),
        .rd_data (rd_data), .irq (irq), .xfer_to_dev (xfer_to_dev),
        .xfer_bytes (xfer_bytes)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_reg [SLOTS];
    int          m_count;
    bit          m_busy, m_pend, m_irq, m_dir;
    int          m_bytes;

    function automatic logic [31:0] model_merge(logic [31:0] o, logic [31:0] d, logic [3:0] l);
        logic [31:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (l[b]) r[8*b +: 8] = 8'h00;
        return r | d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) m_reg[i] = '0;
            m_count = 0; m_busy = 0; m_pend = 0; m_irq = 0; m_dir = 0; m_bytes = 0;
        end else begin
            bit fin;
            fin = m_busy && m_count == 1;
            if (m_busy && m_count > 0) m_count--;
            if (fin) begin m_busy = 0; m_irq = 1; end
            if (wr_en) begin
                int idx;
                idx = int'(wr_addr >> 2);
                if (idx == 4) begin
                    if (wr_data[0]) begin m_busy = 0; m_pend = 0; m_count = 0; end
                    if (wr_data[1]) begin m_irq = 0; m_pend = 0; end
                end else if (idx < NR) begin
                    logic [31:0] nv;
                    nv = model_merge(m_reg[idx], wr_data, wr_lanes);
                    if (idx == 2 || idx == 3) begin
                        if (m_reg[0] == 32'hFFFF_FFFF) begin
                            m_busy = 0; m_pend = 1; m_irq = 1; m_count = 0;
                        end else begin
                            m_bytes = int'(nv[LW-1:0]) + 1;
                            m_count = m_bytes / 2 + EXTRA;
                            m_busy = 1; m_pend = 1; m_dir = (idx == 3);
                        end
                    end
                    m_reg[idx] = nv;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, scanning every read slot.
    always @(posedge clk) begin
        #2;
        if (live) begin
            int ri;
            logic [31:0] exp_rd;
            ri = int'(rd_addr >> 2);
            if (ri >= NR)      exp_rd = '0;
            else if (ri == 4)  exp_rd = {28'd0, m_pend, 2'b00, m_busy};
            else               exp_rd = m_reg[ri];
            check(rd_data == exp_rd, (ri >= NR) ? "R1 unmapped read" : (ri == 4) ? "R3 status read" : "R2 register read",
                  int'(rd_data), int'(exp_rd));
            check(irq == m_irq, "R8 irq", int'(irq), int'(m_irq));
            check(xfer_bytes == (LW+1)'(m_bytes), "R5 xfer_bytes", int'(xfer_bytes), m_bytes);
            check(xfer_to_dev == m_dir, "R5 xfer_to_dev", int'(xfer_to_dev), int'(m_dir));
        end
        #1;
        rd_addr = AW'(((int'(rd_addr >> 2) + 1) % SLOTS) * 4);
    end

    task automatic wr(input int idx, input int lo, input logic [31:0] d, input logic [3:0] l);
        wr_en = 1'b1; wr_addr = AW'(idx * 4 + lo); wr_data = d; wr_lanes = l;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_lanes = '0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 1000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        live = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check(irq == 1'b0, "R9 irq after reset", int'(irq), 0);
        check(xfer_bytes == '0, "R9 bytes after reset", int'(xfer_bytes), 0);
        check(xfer_to_dev == 1'b0, "R9 dir after reset", int'(xfer_to_dev), 0);

        // R2: masked writes to a general register and the device address
        wr(5, 0, 32'h1234_5678, 4'b0000);
        wr(5, 0, 32'h00A0_0000, 4'b0011);
        wr(1, 1, 32'h0000_0F00, 4'b1111);
        // R1: index 7 is unmapped, so the write is dropped
        wr(7, 0, 32'h0000_DEAD, 4'b1111);
        // R1: low two address bits ignored
        wr(5, 3, 32'h0000_0001, 4'b0001);

        // R5/R7/R8: memory-to-device transfer; 0x109 -> low 8 bits 9 -> 10 bytes
        wr(0, 0, 32'h0000_0100, 4'b1111);
        wr(3, 0, 32'h0000_0109, 4'b1111);
        check(xfer_bytes == 9'd10, "R5 byte count", int'(xfer_bytes), 10);
        check(xfer_to_dev == 1'b1, "R5 direction to device", int'(xfer_to_dev), 1);
        wait_irq(n);
        check(n == 10 / 2 + EXTRA, "R7 busy duration", n, 10 / 2 + EXTRA);

        // R4: clear irq command
        wr(4, 0, 32'h0000_0002, 4'b0000);
        check(irq == 1'b0, "R4 irq cleared", int'(irq), 0);

        // R10: restart in flight; second length 0x20 -> 33 bytes
        wr(2, 0, 32'h0000_0004, 4'b1111);
        check(xfer_to_dev == 1'b0, "R5 direction to memory", int'(xfer_to_dev), 0);
        repeat (2) @(negedge clk);
        wr(3, 0, 32'h0000_0020, 4'b1111);
        wait_irq(n);
        check(n == 33 / 2 + EXTRA, "R10 restart duration", n, 33 / 2 + EXTRA);
        wr(4, 0, 32'h0000_0002, 4'b0000);

        // R4: clear-all command cancels completion
        wr(2, 0, 32'h0000_0010, 4'b1111);
        repeat (3) @(negedge clk);
        wr(4, 0, 32'h0000_0001, 4'b0000);
        repeat (20) @(negedge clk);
        check(irq == 1'b0, "R4 no completion after clear", int'(irq), 0);
        check(xfer_bytes == 9'd17, "R4 bytes kept", int'(xfer_bytes), 17);

        // R6: all-ones memory address aborts
        wr(0, 0, 32'hFFFF_FFFF, 4'b1111);
        wr(3, 0, 32'h0000_0005, 4'b1111);
        check(irq == 1'b1, "R6 abort irq", int'(irq), 1);
        check(xfer_bytes == 9'd17, "R6 no start", int'(xfer_bytes), 17);
        check(xfer_to_dev == 1'b0, "R6 direction kept", int'(xfer_to_dev), 0);
        wr(4, 0, 32'h0000_0002, 4'b0000);
        wr(0, 0, 32'h0000_0040, 4'b1111);

        // R3: status data bits without commands are not stored
        wr(4, 0, 32'hFFFF_FFF0, 4'b1111);
        check(irq == 1'b0, "R3 status data no effect", int'(irq), 0);
        repeat (2 * SLOTS) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule